// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time as a chain of byte-wide BCD counters. The chain starts at hundredths of a second and runs up through seconds, minutes, hours, day of week, day of month, month, year and a three-digit day of year. It advances by one hundredth on every clock edge where the 100 Hz enable `tick` is high and the run bit is set. A counter receives a carry only in the cycle its lower neighbour wraps. Every counter moves on the same clock edge, so all bytes always describe the same instant.

A host reads and writes each counter byte through a flat byte register map. The same map holds a control byte with the run bit and the 12/24-hour select. It also holds a status byte with one rollover flag per advance rate.

The host uses the status byte to detect a rollover during a multi-byte read:
- Clear the status byte by reading it.
- Read the counter bytes.
- Read the status byte again.
- If the flag for the fastest byte read is set, repeat the read.

To set the time, the host clears the run bit, writes the counter bytes, and then sets the run bit again.

Top module: `bcd_time_chain`

## Requirements
- R1: After reset the map reads as follows.
  - Hundredths, seconds, minutes, hours and year read 0x00.
  - Day of week, day of month and month read 0x01.
  - Day of year reads 001: address 8 holds 0x01 and address 9 holds 0x00.
  - Control and status read 0x00.
- R2: Three counters count in two-digit BCD.
  - Hundredths (address 0) counts 00 to 99, then returns to 00.
  - Seconds (address 1) counts 00 to 59, then returns to 00.
  - Minutes (address 2) counts 00 to 59, then returns to 00.
  - Each wrap moves the next counter up by one in the same clock edge.
- R3: Hours (address 3) in 24-hour mode depends on control bit 1 being 0.
  - Hours counts 00 to 23 in BCD.
  - Hours advances only when minutes wraps.
  - From 23 it returns to 00 and advances the day counters.
- R4: Hours in 12-hour mode depends on control bit 1 being 1.
  - Bits 4:0 hold the hour, 01 to 12, in BCD. Bit 7 is the PM flag, where 1 means PM.
  - An advance from 11 gives 12 and inverts bit 7.
  - An advance from 12 gives 01 and leaves bit 7 unchanged.
  - The day counters advance only on the step from 11 PM to 12 AM.
- R5: On a day advance, four counters move together.
  - Day of week (address 7) counts 1 to 7, then returns to 1.
  - Day of month (address 4) counts 1 to 31, then returns to 1.
  - When day of month wraps, month (address 5) advances. Month counts 1 to 12, then returns to 1.
  - When month wraps, year (address 6) advances. Year counts 00 to 99, then returns to 00.
- R6: Day of year is a 12-bit, three-digit BCD counter that advances on each day advance.
  - Address 8 holds the tens and units digits.
  - Address 9 bits 3:0 hold the hundreds digit, and bits 7:4 read 0.
  - It counts 001 to 365, then returns to 001.
- R7: The control byte at address 10 has the run bit at bit 0.
  - While the run bit is 0, `tick` changes no counter and sets no status flag.
  - Host writes to counter bytes still take effect while the run bit is 0.
  - Setting the run bit back to 1 resumes counting from the held value.
- R8: The status byte at address 11 has one flag per advance.
  - Bit 0 is hundredths, bit 1 seconds, bit 2 minutes, bit 3 hours, bit 4 day and bit 5 month.
  - A flag is set on the edge where that counter advances.
  - A cycle with `rd_en` high at address 11 returns the flags and clears them on that edge.
  - If an advance happens on the same edge as the clearing read, that flag stays set.
  - Host writes to address 11 have no effect.
- R9: A host write to a counter byte takes priority over an increment of that byte on the same edge.
  - The carry out of that byte is still computed from its value before the write.
- R10: Control bits 1:0 read back as written, and control bits 7:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 100 Hz advance enable, sampled on each clock edge |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; only used to clear the status byte |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data from the byte at `addr`, combinational |

## Verification
A wrong carry term or a wrong terminal value does not stay hidden. On the first edge where the affected counter should wrap, that byte reads the wrong value. Every higher byte then drifts from the arithmetic time the bench keeps, so one tick past each boundary is enough to expose the fault. The bench therefore presets each counter just below its terminal value and advances once:
- for every hour in both modes;
- for every day of month;
- for every day-of-year value.
A fault in the status clear logic or in the write precedence shows up in the cycle right after the conflicting edge.

// File: rtl/bcd_time_chain.sv
module bcd_time_chain #(
  parameter int ADDR_W = 4,
  parameter logic [7:0] DOW_LAST = 8'h07,
  parameter logic [7:0] DOM_LAST = 8'h31,
  parameter logic [7:0] MON_LAST = 8'h12,
  parameter logic [11:0] DOY_LAST = 12'h365
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int NADDR = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_HS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MIN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DOM = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_YR  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_DOW = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_DYL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DYH = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_CT  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(11);

  function automatic logic [7:0] inc2(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [11:0] inc3(input logic [11:0] v);
    if (v[3:0] < 4'd9)      return {v[11:4], v[3:0] + 4'd1};
    else if (v[7:4] < 4'd9) return {v[11:8], v[7:4] + 4'd1, 4'd0};
    else                    return {v[11:8] + 4'd1, 8'h00};
  endfunction

  logic [7:0]  hs_q, sec_q, min_q, hr_q, dom_q, mon_q, yr_q, dow_q;
  logic [11:0] doy_q;
  logic        run_q, m12_q;
  logic [5:0]  stat_q;

  logic [NADDR-1:0] wsel;
  assign wsel = wr_en ? (NADDR'(1) << addr) : '0;

  logic adv, c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  assign adv   = tick & run_q;
  assign c_sec = adv   & (hs_q  >= 8'h99);
  assign c_min = c_sec & (sec_q >= 8'h59);
  assign c_hr  = c_min & (min_q >= 8'h59);
  assign c_day = c_hr  & (m12_q ? (hr_q[4:0] == 5'h11 && hr_q[7]) : (hr_q[5:0] >= 6'h23));
  assign c_mon = c_day & (dom_q >= DOM_LAST);
  assign c_yr  = c_mon & (mon_q >= MON_LAST);

  logic [7:0] hr_nx;
  logic [4:0] h12_inc;
  assign h12_inc = (hr_q[3:0] >= 4'd9) ? {hr_q[4] + 1'b1, 4'd0} : {hr_q[4], hr_q[3:0] + 4'd1};

  always_comb begin
    if (m12_q) begin
      if (hr_q[4:0] == 5'h12)      hr_nx = {hr_q[7], 7'h01};
      else if (hr_q[4:0] == 5'h11) hr_nx = {~hr_q[7], 7'h12};
      else                         hr_nx = {hr_q[7], 2'b00, h12_inc};
    end else begin
      hr_nx = (hr_q[5:0] >= 6'h23) ? 8'h00 : inc2({2'b00, hr_q[5:0]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hs_q <= 8'h00;
    else if (wsel[A_HS]) hs_q <= wdata;
    else if (adv)        hs_q <= (hs_q >= 8'h99) ? 8'h00 : inc2(hs_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sec_q <= 8'h00;
    else if (wsel[A_SEC]) sec_q <= wdata;
    else if (c_sec)       sec_q <= (sec_q >= 8'h59) ? 8'h00 : inc2(sec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           min_q <= 8'h00;
    else if (wsel[A_MIN]) min_q <= wdata;
    else if (c_min)       min_q <= (min_q >= 8'h59) ? 8'h00 : inc2(min_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hr_q <= 8'h00;
    else if (wsel[A_HR]) hr_q <= wdata;
    else if (c_hr)       hr_q <= hr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dow_q <= 8'h01;
    else if (wsel[A_DOW]) dow_q <= wdata;
    else if (c_day)       dow_q <= (dow_q >= DOW_LAST) ? 8'h01 : inc2(dow_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dom_q <= 8'h01;
    else if (wsel[A_DOM]) dom_q <= wdata;
    else if (c_day)       dom_q <= (dom_q >= DOM_LAST) ? 8'h01 : inc2(dom_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mon_q <= 8'h01;
    else if (wsel[A_MON]) mon_q <= wdata;
    else if (c_mon)       mon_q <= (mon_q >= MON_LAST) ? 8'h01 : inc2(mon_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          yr_q <= 8'h00;
    else if (wsel[A_YR]) yr_q <= wdata;
    else if (c_yr)       yr_q <= (yr_q >= 8'h99) ? 8'h00 : inc2(yr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doy_q <= 12'h001;
    else if (wsel[A_DYL] || wsel[A_DYH]) begin
      if (wsel[A_DYL]) doy_q[7:0]  <= wdata;
      if (wsel[A_DYH]) doy_q[11:8] <= wdata[3:0];
    end else if (c_day) doy_q <= (doy_q >= DOY_LAST) ? 12'h001 : inc3(doy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      m12_q <= 1'b0;
    end else if (wsel[A_CT]) begin
      run_q <= wdata[0];
      m12_q <= wdata[1];
    end
  end

  logic rd_clr;
  assign rd_clr = rd_en && (addr == A_ST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (rd_clr ? 6'b0 : stat_q) | {c_mon, c_day, c_hr, c_min, c_sec, adv};
  end

  always_comb begin
    case (addr)
      A_HS:    rdata = hs_q;
      A_SEC:   rdata = sec_q;
      A_MIN:   rdata = min_q;
      A_HR:    rdata = hr_q;
      A_DOM:   rdata = dom_q;
      A_MON:   rdata = mon_q;
      A_YR:    rdata = yr_q;
      A_DOW:   rdata = dow_q;
      A_DYL:   rdata = doy_q[7:0];
      A_DYH:   rdata = {4'h0, doy_q[11:8]};
      A_CT:    rdata = {6'b0, m12_q, run_q};
      A_ST:    rdata = {2'b0, stat_q};
      default: rdata = 8'h00;
    endcase
  end

  p_hsec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hs_q == 8'h99 && !wsel[A_HS]) |=> (hs_q == 8'h00));

  p_hour24_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hr && !m12_q && hr_q == 8'h23 && !wsel[A_HR]) |=> (hr_q == 8'h00));

  p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hr && m12_q && hr_q[4:0] == 5'h11 && !wsel[A_HR]) |=> (hr_q[7] != $past(hr_q[7])));

  p_doy_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_day && doy_q == DOY_LAST && !wsel[A_DYL] && !wsel[A_DYH]) |=> (doy_q == 12'h001));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> ($stable(hs_q) && $stable(sec_q) && $stable(hr_q) && $stable(doy_q)));

  p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> stat_q[0]);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wsel[A_SEC] |=> (sec_q == $past(wdata)));

endmodule

// File: tb/bcd_time_chain_bench.sv
module bcd_time_chain_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_time_chain u_bcd_time_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return {4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clr_stat();
    @(negedge clk); addr = 4'd11; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic end_of_day();
    wr(4'd0, 8'h99); wr(4'd1, 8'h59); wr(4'd2, 8'h59); wr(4'd3, 8'h23);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rdchk("R1 hs", 4'd0, 8'h00); rdchk("R1 sec", 4'd1, 8'h00);
    rdchk("R1 min", 4'd2, 8'h00); rdchk("R1 hr", 4'd3, 8'h00);
    rdchk("R1 dom", 4'd4, 8'h01); rdchk("R1 mon", 4'd5, 8'h01);
    rdchk("R1 yr", 4'd6, 8'h00); rdchk("R1 dow", 4'd7, 8'h01);
    rdchk("R1 doyl", 4'd8, 8'h01); rdchk("R1 doyh", 4'd9, 8'h00);
    rdchk("R1 ctrl", 4'd10, 8'h00); rdchk("R1 stat", 4'd11, 8'h00);

    // R10 control readback, R8 status write ignored
    wr(4'd10, 8'hFE); rdchk("R10 ctrl", 4'd10, 8'h02);
    wr(4'd11, 8'hFF); rdchk("R8 stat write ignored", 4'd11, 8'h00);
    wr(4'd10, 8'h01); rdchk("R10 ctrl", 4'd10, 8'h01);

    // R2 sweep over two minutes, one tick per cycle
    @(negedge clk); tick = 1'b1;
    for (int k = 1; k <= 12000; k++) begin
      @(negedge clk);
      rdchk("R2 hs", 4'd0, bcd(k % 100));
      rdchk("R2 sec", 4'd1, bcd((k / 100) % 60));
      rdchk("R2 min", 4'd2, bcd(k / 6000));
    end
    tick = 1'b0;
    rdchk("R2 hr", 4'd3, 8'h00);

    // R3 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      wr(4'd0, 8'h99); wr(4'd1, 8'h59); wr(4'd2, 8'h59);
      wr(4'd3, bcd(h)); wr(4'd4, 8'h05);
      tick1();
      rdchk("R3 hour", 4'd3, bcd((h + 1) % 24));
      rdchk("R3 min", 4'd2, 8'h00);
      rdchk("R3 day carry", 4'd4, (h == 23) ? 8'h06 : 8'h05);
    end

    // R4 12-hour sweep
    wr(4'd10, 8'h03);
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        logic [7:0] exp_hr;
        wr(4'd0, 8'h99); wr(4'd1, 8'h59); wr(4'd2, 8'h59);
        wr(4'd3, {pm[0], 2'b00, 5'(bcd(h))}); wr(4'd4, 8'h05);
        tick1();
        if (h == 11)      exp_hr = {~pm[0], 7'h12};
        else if (h == 12) exp_hr = {pm[0], 7'h01};
        else              exp_hr = {pm[0], 2'b00, 5'(bcd(h + 1))};
        rdchk("R4 hour", 4'd3, exp_hr);
        rdchk("R4 day carry", 4'd4, (h == 11 && pm == 1) ? 8'h06 : 8'h05);
      end
    end
    wr(4'd10, 8'h01);

    // R5 day, week, month, year
    for (int d = 1; d <= 31; d++) begin
      int m, w, y;
      m = ((d - 1) % 12) + 1; w = ((d - 1) % 7) + 1; y = (d * 3) % 100;
      end_of_day();
      wr(4'd4, bcd(d)); wr(4'd5, bcd(m)); wr(4'd7, bcd(w)); wr(4'd6, bcd(y));
      tick1();
      rdchk("R5 dow", 4'd7, bcd(w == 7 ? 1 : w + 1));
      rdchk("R5 dom", 4'd4, bcd(d == 31 ? 1 : d + 1));
      rdchk("R5 mon", 4'd5, bcd(d == 31 ? m + 1 : m));
      rdchk("R5 yr", 4'd6, bcd(y));
      rdchk("R2 hr wrap", 4'd3, 8'h00);
    end
    end_of_day();
    wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    tick1();
    rdchk("R5 dom new year", 4'd4, 8'h01);
    rdchk("R5 mon new year", 4'd5, 8'h01);
    rdchk("R5 yr wrap", 4'd6, 8'h00);

    // R6 day-of-year sweep
    for (int v = 1; v <= 365; v++) begin
      int e;
      e = (v == 365) ? 1 : v + 1;
      end_of_day();
      wr(4'd8, bcd(v % 100)); wr(4'd9, 8'(v / 100));
      tick1();
      rdchk("R6 doy low", 4'd8, bcd(e % 100));
      rdchk("R6 doy high", 4'd9, 8'(e / 100));
    end

    // R8 status set and read clear
    wr(4'd0, 8'h99); wr(4'd1, 8'h05);
    clr_stat();
    rdchk("R8 stat cleared", 4'd11, 8'h00);
    tick1();
    rdchk("R8 stat set", 4'd11, 8'h03);
    clr_stat();
    rdchk("R8 stat after read", 4'd11, 8'h00);
    @(negedge clk); tick = 1'b1; addr = 4'd11; rd_en = 1'b1;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    rdchk("R8 set wins over clear", 4'd11, 8'h01);

    // R9 write beats increment, carry from old value
    wr(4'd0, 8'h99); wr(4'd1, 8'h10);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 8'h42;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rdchk("R9 hs written", 4'd0, 8'h42);
    rdchk("R9 carry still taken", 4'd1, 8'h11);

    // R7 stop, write while stopped, resume
    wr(4'd10, 8'h00);
    wr(4'd0, 8'h50); wr(4'd1, 8'h30);
    clr_stat();
    @(negedge clk); tick = 1'b1;
    repeat (50) @(negedge clk);
    tick = 1'b0;
    rdchk("R7 hs held", 4'd0, 8'h50);
    rdchk("R7 sec held", 4'd1, 8'h30);
    rdchk("R7 no status", 4'd11, 8'h00);
    wr(4'd1, 8'h45);
    rdchk("R7 write while stopped", 4'd1, 8'h45);
    wr(4'd10, 8'h01);
    tick1();
    rdchk("R7 resume", 4'd0, 8'h51);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule